// File: doc/BRIEF.md
# Output Compare Pin Action Unit

This block sits beside a 16-bit free-running timer and decides what six output compare pins do. Comparators outside the block send a one-cycle strobe per channel when the counter matches. The counter sends a one-cycle strobe when it overflows. Software can also request a forced compare on any channel. Each channel holds an output latch. The event that reaches the channel updates the latch according to the channel's two-bit action code.

Four byte-wide registers set the behaviour:
- two bytes hold the action codes;
- one byte holds a per-channel toggle-on-overflow enable;
- one byte holds a per-channel pin-disconnect bit.

A channel whose action code is nonzero owns its pin and drives the latch onto it, unless its disconnect bit is set. An overflow toggle on an active channel wins over a compare match or a forced compare in the same cycle.

Top module: `ocpin_unit`

## Requirements
- R1: After a synchronous active-low reset, all register bits, all pin levels and all pin enables are 0.
- R2: Address 0x8 holds the action codes of channels 4 and 5 in bits 3:0 as {mode5, level5, mode4, level4}. Writes to bits 7:4 are ignored and those bits read as 0.
- R3: Address 0x9 holds the action codes of channels 3 to 0 as {mode3, level3, mode2, level2, mode1, level1, mode0, level0}, and it reads back what was written.
- R4: Address 0xA holds the toggle-on-overflow enables and address 0xB holds the disconnect bits, one bit per channel in bits 5:0 with bit n for channel n. Bits 7:6 of both read as 0.
- R5: pin_oe[n] is 1 exactly when the action code of channel n is nonzero and its disconnect bit is 0. It follows a register write one clock later.
- R6: A cmp_hit[n] pulse applies the action code {mode, level} of channel n at the next clock edge: 00 leaves the level, 01 toggles it, 10 drives it to 0 and 11 drives it to 1.
- R7: A frc_req[n] pulse applies the same action as a compare match on channel n.
- R8: An ovf_pulse toggles the level of every channel whose overflow enable is 1 and whose action code is nonzero. A channel with action code 00 keeps its level.
- R9: When an overflow toggle applies to a channel, it overrides a compare match or a forced compare on that channel in the same cycle.
- R10: Setting a disconnect bit drops the pin enable and leaves the channel's latched level unchanged. Events still update the latch while the channel is disconnected.
- R11: A read from an address with no register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register address for reads and writes |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rdata | output | DATA_W (8) | Read data for reg_addr, combinational |
| cmp_hit | input | NUM_CH (6) | Per-channel compare-match pulse |
| frc_req | input | NUM_CH (6) | Per-channel forced-compare pulse |
| ovf_pulse | input | 1 | Counter overflow pulse |
| pin_level | output | NUM_CH (6) | Output latch level per channel |
| pin_oe | output | NUM_CH (6) | Pin output enable per channel |

## Verification
The bench builds the block with its defaults: six channels, byte-wide registers and a four-bit address. With these values the action codes of channels 4 and 5 fall into the upper control byte, so the reserved upper nibble and the split between the two bytes can be tested. Directed sequences use channels that hold set or clear codes. On those channels an overflow toggle and a competing match or force give different results, so the priority of R9 can be seen at the pins. A random phase then mixes events and register writes, and every clock is compared with a behavioural model.

// File: rtl/ocp_pkg.sv
// Package ocp_pkg
// Shared types and register offsets for the output compare pin action unit.
// Assumes byte-wide registers and a four-bit register address.
package ocp_pkg;

    // Two-bit per-channel action, written as {mode, level}
    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } pin_act_e;

    localparam logic [3:0] ADR_ACT_HI  = 4'h8;
    localparam logic [3:0] ADR_ACT_LO  = 4'h9;
    localparam logic [3:0] ADR_OVF_TGL = 4'hA;
    localparam logic [3:0] ADR_DISC    = 4'hB;

endpackage

// File: rtl/ocp_regs.sv
// Module ocp_regs
// Register file of the unit: action codes, overflow toggle enables and
// disconnect bits. Reads are combinational and writes take effect at the
// clock edge.
// Assumes NUM_CH lies between DATA_W/2+1 and DATA_W, so that the lower
// control byte is full and the upper one is partly used.
module ocp_regs #(
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic [2*NUM_CH-1:0]   act,
    output logic [NUM_CH-1:0]     tgl_en,
    output logic [NUM_CH-1:0]     disc
);
    import ocp_pkg::*;

    localparam int unsigned LO_CH = DATA_W / 2;
    localparam int unsigned HI_CH = NUM_CH - LO_CH;

    logic [2*NUM_CH-1:0] act_q;
    logic [NUM_CH-1:0]   tgl_q;
    logic [NUM_CH-1:0]   disc_q;

    // Register update: apply a write to the addressed register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            tgl_q  <= '0;
            disc_q <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(ADR_ACT_LO))
                act_q[DATA_W-1:0] <= wdata;
            if (addr == ADDR_W'(ADR_ACT_HI))
                act_q[2*NUM_CH-1:DATA_W] <= wdata[2*HI_CH-1:0];
            if (addr == ADDR_W'(ADR_OVF_TGL))
                tgl_q <= wdata[NUM_CH-1:0];
            if (addr == ADDR_W'(ADR_DISC))
                disc_q <= wdata[NUM_CH-1:0];
        end
    end

    // Read mux: unused bits and unmapped addresses return zero
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADR_ACT_LO))
            rdata = act_q[DATA_W-1:0];
        else if (addr == ADDR_W'(ADR_ACT_HI))
            rdata[2*HI_CH-1:0] = act_q[2*NUM_CH-1:DATA_W];
        else if (addr == ADDR_W'(ADR_OVF_TGL))
            rdata[NUM_CH-1:0] = tgl_q;
        else if (addr == ADDR_W'(ADR_DISC))
            rdata[NUM_CH-1:0] = disc_q;
    end

    assign act    = act_q;
    assign tgl_en = tgl_q;
    assign disc   = disc_q;

endmodule

// File: rtl/ocp_chan.sv
// Module ocp_chan
// Output latch and pin-enable logic of one channel. An overflow toggle has
// priority over a compare match or a forced compare. A channel with action
// code 00 does not take part in overflow toggling.
// Assumes the event inputs are single-cycle pulses.
module ocp_chan (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] act,
    input  logic       tgl_en,
    input  logic       disc,
    input  logic       cmp_hit,
    input  logic       frc_req,
    input  logic       ovf_pulse,
    output logic       level,
    output logic       oe
);
    import ocp_pkg::*;

    logic level_q;
    logic level_nxt;
    logic armed;

    assign armed = (act != ACT_NONE);

    // Next-level selection: overflow toggle first, then match or force
    always_comb begin
        level_nxt = level_q;
        if (ovf_pulse && tgl_en && armed) begin
            level_nxt = ~level_q;
        end else if (cmp_hit || frc_req) begin
            case (pin_act_e'(act))
                ACT_TOGGLE: level_nxt = ~level_q;
                ACT_CLEAR:  level_nxt = 1'b0;
                ACT_SET:    level_nxt = 1'b1;
                default:    level_nxt = level_q;
            endcase
        end
    end

    // Output latch: keeps its value whatever the pin enable is
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_nxt;
    end

    assign level = level_q;
    assign oe    = armed & ~disc;

endmodule

// File: rtl/ocpin_unit.sv
// Module ocpin_unit
// Top of the output compare pin action unit: one register file and
// NUM_CH channel slices.
// Assumes the match, force and overflow inputs come from the timer core
// as single-cycle pulses synchronous to clk.
module ocpin_unit #(
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] cmp_hit,
    input  logic [NUM_CH-1:0] frc_req,
    input  logic              ovf_pulse,
    output logic [NUM_CH-1:0] pin_level,
    output logic [NUM_CH-1:0] pin_oe
);

    logic [2*NUM_CH-1:0] act_w;
    logic [NUM_CH-1:0]   tgl_w;
    logic [NUM_CH-1:0]   disc_w;

    ocp_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .act    (act_w),
        .tgl_en (tgl_w),
        .disc   (disc_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ocp_chan chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .act       (act_w[2*g +: 2]),
            .tgl_en    (tgl_w[g]),
            .disc      (disc_w[g]),
            .cmp_hit   (cmp_hit[g]),
            .frc_req   (frc_req[g]),
            .ovf_pulse (ovf_pulse),
            .level     (pin_level[g]),
            .oe        (pin_oe[g])
        );
    end

endmodule

// File: rtl/ocp_checker.sv
// Module ocp_checker
// Properties of the pin action unit, bound to every ocpin_unit instance.
// Assumes it sees the register outputs through the bind connection.
module ocp_checker #(
    parameter int unsigned NUM_CH = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] cmp_hit,
    input logic [NUM_CH-1:0] frc_req,
    input logic              ovf_pulse,
    input logic [2*NUM_CH-1:0] act,
    input logic [NUM_CH-1:0] tgl_en,
    input logic [NUM_CH-1:0] disc,
    input logic [NUM_CH-1:0] pin_level,
    input logic [NUM_CH-1:0] pin_oe
);

    // R1: one clock in reset clears levels and enables
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pin_level == '0 && pin_oe == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R5: a disconnected channel never drives its pin
        a_r5_disc_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            disc[g] |-> !pin_oe[g]);

        // R6: a set code with a match or force and no overflow toggle gives 1
        a_r6_set_level: assert property (@(posedge clk) disable iff (!rst_n)
            (!(ovf_pulse && tgl_en[g]) && (cmp_hit[g] || frc_req[g]) &&
             act[2*g +: 2] == 2'b11) |=> pin_level[g]);

        // R6: a clear code with a match or force and no overflow toggle gives 0
        a_r6_clear_level: assert property (@(posedge clk) disable iff (!rst_n)
            (!(ovf_pulse && tgl_en[g]) && (cmp_hit[g] || frc_req[g]) &&
             act[2*g +: 2] == 2'b10) |=> !pin_level[g]);

        // R9: an active overflow toggle always flips the level
        a_r9_ovf_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_pulse && tgl_en[g] && act[2*g +: 2] != 2'b00) |=>
            (pin_level[g] != $past(pin_level[g])));

        // R10: with no event the latch holds, whatever the enables do
        a_r10_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!ovf_pulse && !cmp_hit[g] && !frc_req[g]) |=> $stable(pin_level[g]));
    end

endmodule

bind ocpin_unit ocp_checker #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_hit   (cmp_hit),
    .frc_req   (frc_req),
    .ovf_pulse (ovf_pulse),
    .act       (act_w),
    .tgl_en    (tgl_w),
    .disc      (disc_w),
    .pin_level (pin_level),
    .pin_oe    (pin_oe)
);

// File: tb/ocpin_unit_tb.sv
`timescale 1ns/1ps
// Bench for ocpin_unit: a behavioural reference model is compared on every
// clock, and directed checks cover registers and priorities.
module ocpin_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [5:0] cmp_hit = '0;
    logic [5:0] frc_req = '0;
    logic       ovf_pulse = 1'b0;
    logic [5:0] pin_level;
    logic [5:0] pin_oe;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ocpin_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cmp_hit   (cmp_hit),
        .frc_req   (frc_req),
        .ovf_pulse (ovf_pulse),
        .pin_level (pin_level),
        .pin_oe    (pin_oe)
    );

    // Reference model state
    int m_act[6];
    bit m_tgl[6];
    bit m_disc[6];
    bit m_lvl[6];

    // Model update at each rising edge, events first, using the old registers
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 6; k++) begin
                m_act[k] = 0; m_tgl[k] = 0; m_disc[k] = 0; m_lvl[k] = 0;
            end
        end else begin
            for (int k = 0; k < 6; k++) begin
                if (ovf_pulse && m_tgl[k] && m_act[k] != 0)
                    m_lvl[k] = !m_lvl[k];
                else if (cmp_hit[k] || frc_req[k]) begin
                    if (m_act[k] == 1) m_lvl[k] = !m_lvl[k];
                    else if (m_act[k] == 2) m_lvl[k] = 0;
                    else if (m_act[k] == 3) m_lvl[k] = 1;
                end
            end
            if (reg_wr) begin
                if (reg_addr == 4'h8) begin
                    m_act[4] = int'(reg_wdata[1:0]);
                    m_act[5] = int'(reg_wdata[3:2]);
                end
                if (reg_addr == 4'h9)
                    for (int k = 0; k < 4; k++) m_act[k] = int'(reg_wdata[2*k +: 2]);
                if (reg_addr == 4'hA)
                    for (int k = 0; k < 6; k++) m_tgl[k] = reg_wdata[k];
                if (reg_addr == 4'hB)
                    for (int k = 0; k < 6; k++) m_disc[k] = reg_wdata[k];
            end
        end
    end

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        logic [5:0] e_lvl;
        logic [5:0] e_oe;
        if (!finished) begin
            for (int k = 0; k < 6; k++) begin
                e_lvl[k] = m_lvl[k];
                e_oe[k]  = (m_act[k] != 0) && !m_disc[k];
            end
            total++;
            if (pin_level !== e_lvl) begin
                bad++;
                $display("FAIL R6 model level actual=%b expected=%b", pin_level, e_lvl);
            end
            total++;
            if (pin_oe !== e_oe) begin
                bad++;
                $display("FAIL R5 model enable actual=%b expected=%b", pin_oe, e_oe);
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] act_v, input logic [7:0] exp_v);
        total++;
        if (act_v !== exp_v) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [3:0] a, input logic [7:0] exp_v);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp_v);
    endtask

    task automatic pulse(input logic [5:0] h, input logic [5:0] f, input logic o);
        @(negedge clk);
        cmp_hit = h; frc_req = f; ovf_pulse = o;
        @(negedge clk);
        cmp_hit = '0; frc_req = '0; ovf_pulse = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 level", {2'b00, pin_level}, 8'h00);
        check("R1 enable", {2'b00, pin_oe}, 8'h00);
        rd_check("R1 act_hi", 4'h8, 8'h00);
        rd_check("R1 act_lo", 4'h9, 8'h00);
        rd_check("R1 tgl", 4'hA, 8'h00);
        rd_check("R1 disc", 4'hB, 8'h00);

        // R2: reserved nibble of the upper byte
        wr(4'h8, 8'hFF);
        rd_check("R2 act_hi", 4'h8, 8'h0F);
        // R3: lower byte round trip
        wr(4'h9, 8'hA5);
        rd_check("R3 act_lo", 4'h9, 8'hA5);
        // R4: per-channel bytes
        wr(4'hA, 8'hFF);
        rd_check("R4 tgl", 4'hA, 8'h3F);
        wr(4'hB, 8'hFF);
        rd_check("R4 disc", 4'hB, 8'h3F);
        // R11: unmapped address
        wr(4'h3, 8'hFF);
        rd_check("R11 unmapped", 4'h3, 8'h00);
        rd_check("R11 unmapped hi", 4'hF, 8'h00);

        // Clear and set codes: ch0 toggle, ch1 clear, ch2 set, ch3 none, ch4 set, ch5 toggle
        wr(4'hA, 8'h00);
        wr(4'hB, 8'h00);
        wr(4'h9, 8'h39);
        wr(4'h8, 8'h07);
        #1;
        check("R5 enables", {2'b00, pin_oe}, 8'h37);

        pulse(6'h3F, 6'h00, 1'b0);
        check("R6 match actions", {2'b00, pin_level}, 8'h35);

        pulse(6'h00, 6'h09, 1'b0);
        check("R7 force actions", {2'b00, pin_level}, 8'h34);

        wr(4'hA, 8'h09);
        pulse(6'h00, 6'h00, 1'b1);
        check("R8 overflow toggle", {2'b00, pin_level}, 8'h35);

        wr(4'hA, 8'h14);
        pulse(6'h04, 6'h10, 1'b1);
        check("R9 overflow wins", {2'b00, pin_level}, 8'h21);

        wr(4'hB, 8'h20);
        #1;
        check("R10 enable drop", {2'b00, pin_oe}, 8'h17);
        check("R10 level kept", {2'b00, pin_level}, 8'h21);
        pulse(6'h20, 6'h00, 1'b0);
        check("R10 latch runs", {2'b00, pin_level}, 8'h01);
        wr(4'hB, 8'h00);
        #1;
        check("R10 reconnect", {2'b00, pin_oe}, 8'h37);

        // Random phase, checked by the model each clock
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            cmp_hit   = 6'($urandom);
            frc_req   = ($urandom % 4 == 0) ? 6'($urandom) : 6'h00;
            ovf_pulse = ($urandom % 5 == 0);
            reg_wr    = ($urandom % 6 == 0);
            reg_addr  = 4'h8 + 4'($urandom % 4);
            reg_wdata = 8'($urandom);
        end
        @(negedge clk);
        cmp_hit = '0; frc_req = '0; ovf_pulse = 1'b0; reg_wr = 1'b0;
        repeat (2) @(negedge clk);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule